// File: doc/BRIEF.md
# Field-Packed Control and Status Register

This block is one memory-mapped register made of a parameter-defined list of fields. Each field has its own access mode. On one side is a plain register-bus port: an already-decoded select, read and write strobes, write data, and registered read data. On the other side is the peripheral. It sees every stored field value, gets a write strobe for each field, and drives read-only values plus set and clear requests for the flag fields.

Only one side may change a field's state. A bus read-write field, for example, can only be observed by the peripheral. The flag fields are the only exception, and they split the job: one side may only raise the bit and the other may only lower it. Two reserved kinds differ in what a bus write does to their storage. One zeroes it. The other leaves it untouched, and the peripheral cannot touch it either.

Field widths and modes are packed parameters, with field 0 in the lowest slot. Mode codes are RO=0, WO=1, RW=2, W1C=3, W1S=4, RSV0=5, RSVK=6. With the default parameters the register holds seven fields and is 20 bits wide on a 32-bit bus.

Top module: `csr_field_reg`

## Requirements
- R1: Fields are packed from bit 0 upward in list order, each one starting at the sum of the earlier widths. The default layout is RW [3:0], RO [7:4], WO [11:8], W1C [13:12], W1S [15:14], RSV0 [17:16] and RSVK [19:18]. Read-data bits above the register width always read 0.
- R2: A bus write to a RW field stores the written bits. The new value appears on per_q one cycle after the write strobe and reads back over the bus. Nothing on the peripheral side can change it.
- R3: A bus read of a RO field returns per_in for that field. Bus writes have no effect on it, and its per_q bits stay 0.
- R4: A WO field reads as 0 on the bus and presents its last written data on per_q. A per_wstb bit pulses for exactly one cycle after each bus write to a RW or WO field. The strobe is at that field's index, so the default layout gives 7'b0000101.
- R5: A W1C bit is set by per_set. A bus write of 1 clears it, and a bus write of 0 leaves it unchanged.
- R6: A W1S bit is set by a bus write of 1 and cleared by per_clr. A bus write of 0 leaves it unchanged.
- R7: When a set and a clear reach the same flag bit in the same cycle, the bit ends up set. This holds for both flag kinds.
- R8: A RSV0 field stores 0 after any bus write to the register, whatever the written data.
- R9: A RSVK field keeps its reset value through bus writes and peripheral activity.
- R10: Read data appears one cycle after the read strobe and is 0 in every other cycle. A read issued together with a write returns the contents from before the write.
- R11: A synchronous active-high reset loads each stored field's reset value (default 32'h000B_0005 for the register) and clears read data and strobes.
- R12: With select low, read and write strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register selected by the address decoder |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| per_in | input | REG_W | Peripheral values for RO fields |
| per_set | input | REG_W | Set requests for W1C bits |
| per_clr | input | REG_W | Clear requests for W1S bits |
| per_q | output | REG_W | Stored field values seen by the peripheral |
| per_wstb | output | NF | Per-field write strobe for RW and WO fields |

## Verification
A wrong stored bit shows on per_q one cycle after the edge that stored it. It shows on bus_rdata one cycle after the next read. Mis-packed offsets show up as a value appearing in a neighbouring field's bit range. Set/clear priority mistakes only show under simultaneous set and clear of a flag bit, so that case is driven for both flag kinds in the same cycle. A strobe bug shows as per_wstb high for a cycle with no write, or for longer than one cycle.

// File: rtl/csr_fld_pkg.sv
package csr_fld_pkg;
  localparam int MAXF = 16;
  localparam int MAXW = 256;

  typedef enum logic [2:0] {
    FM_RO   = 3'd0,
    FM_WO   = 3'd1,
    FM_RW   = 3'd2,
    FM_W1C  = 3'd3,
    FM_W1S  = 3'd4,
    FM_RSV0 = 3'd5,
    FM_RSVK = 3'd6
  } fld_mode_e;

  function automatic int fld_width(input logic [MAXF*8-1:0] w, input int i);
    return int'(w[i*8 +: 8]);
  endfunction

  // Offset is the sum of all earlier widths (packed from bit 0)
  function automatic int fld_off(input logic [MAXF*8-1:0] w, input int i);
    int s;
    s = 0;
    for (int j = 0; j < i; j++) s += fld_width(w, j);
    return s;
  endfunction

  function automatic int reg_width(input logic [MAXF*8-1:0] w, input int nf);
    return fld_off(w, nf);
  endfunction

  // Bit mask of every bit that belongs to a field of the given mode
  function automatic logic [MAXW-1:0] mode_mask(input logic [MAXF*8-1:0] w,
                                                input logic [MAXF*3-1:0] m,
                                                input int nf,
                                                input fld_mode_e md);
    logic [MAXW-1:0] r;
    r = '0;
    for (int i = 0; i < nf; i++) begin
      if (m[i*3 +: 3] == md) begin
        for (int b = 0; b < fld_width(w, i); b++) r[fld_off(w, i) + b] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/csr_fld_slice.sv
module csr_fld_slice
  import csr_fld_pkg::*;
#(
  parameter int        W    = 1,
  parameter fld_mode_e MODE = FM_RW,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] per_set,
  input  logic [W-1:0] per_clr,
  output logic [W-1:0] q,
  output logic [W-1:0] rd_val,
  output logic         wstb
);
  localparam bit HAS_STB = (MODE == FM_RW) || (MODE == FM_WO);

  logic [W-1:0] q_reg;
  logic [W-1:0] q_nxt;
  logic [W-1:0] bus_ones;

  assign bus_ones = wr_en ? wdata : '0;

  // Flag kinds: the setting term is OR-ed last so a set always wins
  always_comb begin
    case (MODE)
      FM_RW, FM_WO: q_nxt = wr_en ? wdata : q_reg;
      FM_W1C:       q_nxt = (q_reg & ~bus_ones) | per_set;
      FM_W1S:       q_nxt = (q_reg & ~per_clr) | bus_ones;
      FM_RSV0:      q_nxt = wr_en ? '0 : q_reg;
      default:      q_nxt = q_reg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_reg <= RST;
      wstb  <= 1'b0;
    end else begin
      q_reg <= q_nxt;
      wstb  <= wr_en && HAS_STB;
    end
  end

  always_comb begin
    case (MODE)
      FM_RO:   rd_val = per_in;
      FM_WO:   rd_val = '0;
      default: rd_val = q_reg;
    endcase
  end

  assign q = (MODE == FM_RO) ? '0 : q_reg;
endmodule

// File: rtl/csr_rd_path.sv
module csr_rd_path #(
  parameter int REG_W = 8,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [REG_W-1:0] rd_val,
  output logic [BUS_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? BUS_W'(rd_val) : '0;
  end
endmodule

// File: rtl/csr_field_reg.sv
module csr_field_reg
  import csr_fld_pkg::*;
#(
  parameter int NF    = 7,
  parameter int BUS_W = 32,
  parameter logic [NF*8-1:0] FLD_W = {8'd2, 8'd2, 8'd2, 8'd2, 8'd4, 8'd4, 8'd4},
  parameter logic [NF*3-1:0] FLD_M = {3'd6, 3'd5, 3'd4, 3'd3, 3'd1, 3'd0, 3'd2},
  parameter logic [BUS_W-1:0] RST_VAL = 32'h000B_0005,
  localparam int REG_W = reg_width((MAXF*8)'(FLD_W), NF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [REG_W-1:0] per_in,
  input  logic [REG_W-1:0] per_set,
  input  logic [REG_W-1:0] per_clr,
  output logic [REG_W-1:0] per_q,
  output logic [NF-1:0]    per_wstb
);
  localparam logic [MAXF*8-1:0] W_ALL = (MAXF*8)'(FLD_W);

  logic             wr_hit;
  logic             rd_hit;
  logic [REG_W-1:0] rd_val;

  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & bus_rd;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam int OFF = fld_off(W_ALL, i);
    localparam int FW  = fld_width(W_ALL, i);
    csr_fld_slice #(
      .W    (FW),
      .MODE (fld_mode_e'(FLD_M[i*3 +: 3])),
      .RST  (RST_VAL[OFF +: FW])
    ) u_slice (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_hit),
      .wdata   (bus_wdata[OFF +: FW]),
      .per_in  (per_in[OFF +: FW]),
      .per_set (per_set[OFF +: FW]),
      .per_clr (per_clr[OFF +: FW]),
      .q       (per_q[OFF +: FW]),
      .rd_val  (rd_val[OFF +: FW]),
      .wstb    (per_wstb[i])
    );
  end

  if (REG_W < BUS_W) begin : g_hi
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:REG_W];
  end

  csr_rd_path #(
    .REG_W (REG_W),
    .BUS_W (BUS_W)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_hit),
    .rd_val (rd_val),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/csr_field_reg_chk.sv
module csr_field_reg_chk
  import csr_fld_pkg::*;
#(
  parameter int NF    = 7,
  parameter int BUS_W = 32,
  parameter logic [NF*8-1:0] FLD_W = {8'd2, 8'd2, 8'd2, 8'd2, 8'd4, 8'd4, 8'd4},
  parameter logic [NF*3-1:0] FLD_M = {3'd6, 3'd5, 3'd4, 3'd3, 3'd1, 3'd0, 3'd2},
  parameter logic [BUS_W-1:0] RST_VAL = 32'h000B_0005,
  localparam int REG_W = reg_width((MAXF*8)'(FLD_W), NF)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_hit,
  input logic             rd_hit,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [REG_W-1:0] per_set,
  input logic [REG_W-1:0] per_q,
  input logic [NF-1:0]    per_wstb
);
  localparam logic [MAXF*8-1:0] WA = (MAXF*8)'(FLD_W);
  localparam logic [MAXF*3-1:0] MA = (MAXF*3)'(FLD_M);
  localparam logic [MAXW-1:0] F_RW   = mode_mask(WA, MA, NF, FM_RW) | mode_mask(WA, MA, NF, FM_WO);
  localparam logic [MAXW-1:0] F_W1C  = mode_mask(WA, MA, NF, FM_W1C);
  localparam logic [MAXW-1:0] F_RSV0 = mode_mask(WA, MA, NF, FM_RSV0);
  localparam logic [MAXW-1:0] F_RSVK = mode_mask(WA, MA, NF, FM_RSVK);
  localparam logic [REG_W-1:0] M_RW   = F_RW[REG_W-1:0];
  localparam logic [REG_W-1:0] M_W1C  = F_W1C[REG_W-1:0];
  localparam logic [REG_W-1:0] M_RSV0 = F_RSV0[REG_W-1:0];
  localparam logic [REG_W-1:0] M_RSVK = F_RSVK[REG_W-1:0];
  localparam logic [REG_W-1:0] K_RST  = RST_VAL[REG_W-1:0] & M_RSVK;

  logic [REG_W-1:0] bus_clr;
  logic [REG_W-1:0] w1c_keep;
  logic [REG_W-1:0] w1c_setv;

  assign bus_clr  = wr_hit ? bus_wdata[REG_W-1:0] : '0;
  assign w1c_keep = per_q & M_W1C & ~bus_clr;
  assign w1c_setv = per_set & M_W1C;

  AST_RW_ONLY_BUS: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(per_q & M_RW)); // R2
  AST_STB_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> per_wstb == '0); // R4
  AST_W1C_ZERO_NOOP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (per_q & $past(w1c_keep)) == $past(w1c_keep)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    w1c_setv != '0 |=> (per_q & $past(w1c_setv)) == $past(w1c_setv)); // R7
  AST_RSV0_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (per_q & M_RSV0) == '0); // R8
  AST_RSVK_CONST: assert property (@(posedge clk) disable iff (rst)
    (per_q & M_RSVK) == K_RST); // R9
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> bus_rdata == '0); // R10

  if (REG_W < BUS_W) begin : g_hi
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      bus_rdata[BUS_W-1:REG_W] == '0); // R1
  end
endmodule

bind csr_field_reg csr_field_reg_chk #(
  .NF (NF), .BUS_W (BUS_W), .FLD_W (FLD_W), .FLD_M (FLD_M), .RST_VAL (RST_VAL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_hit    (wr_hit),
  .rd_hit    (rd_hit),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .per_set   (per_set),
  .per_q     (per_q),
  .per_wstb  (per_wstb)
);

// File: tb/tb_csr_field_reg.sv
module tb_csr_field_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [19:0] per_in = '0, per_set = '0, per_clr = '0;
  logic [19:0] per_q;
  logic [6:0]  per_wstb;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  csr_field_reg dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_in(per_in),
    .per_set(per_set), .per_clr(per_clr), .per_q(per_q), .per_wstb(per_wstb)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic        rd;
    logic [31:0] wd;
    logic [19:0] pin;
    logic [19:0] pset;
    logic [19:0] pclr;
    logic [31:0] erd;
    logic [19:0] eq;
  } vec_t;

  // Layout (R1): f0 RW[3:0] f1 RO[7:4] f2 WO[11:8] f3 W1C[13:12]
  // f4 W1S[15:14] f5 RSV0[17:16] f6 RSVK[19:18]
  localparam vec_t VEC [9] = '{
    '{4'd3,  1'b0, 1'b1, 32'h0000_0000, 20'h00030, 20'h0, 20'h0, 32'h000B_0035, 20'hB0005}, // R3
    '{4'd2,  1'b1, 1'b0, 32'hFFFF_FFFF, 20'h0, 20'h0, 20'h0, 32'h0000_0000, 20'h8CF0F},    // R2
    '{4'd4,  1'b0, 1'b1, 32'h0000_0000, 20'h000A0, 20'h0, 20'h0, 32'h0008_C0AF, 20'h8CF0F}, // R4
    '{4'd5,  1'b0, 1'b1, 32'h0000_0000, 20'h0, 20'h03000, 20'h04000, 32'h0008_C00F, 20'h8BF0F}, // R5
    '{4'd6,  1'b1, 1'b0, 32'h0000_1000, 20'h0, 20'h0, 20'h0, 32'h0000_0000, 20'h8A000},    // R6
    '{4'd7,  1'b1, 1'b1, 32'h0000_2000, 20'h00050, 20'h02000, 20'h0, 32'h0008_A050, 20'h8A000}, // R7
    '{4'd7,  1'b1, 1'b0, 32'h0000_4000, 20'h0, 20'h0, 20'h04000, 32'h0000_0000, 20'h8E000}, // R7
    '{4'd8,  1'b1, 1'b0, 32'hFFF0_0000, 20'h0, 20'h0, 20'h0, 32'h0000_0000, 20'h8E000},    // R8
    '{4'd9,  1'b0, 1'b1, 32'h0000_0000, 20'h0, 20'h0, 20'h0, 32'h0008_E000, 20'h8E000}     // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    per_set = '0; per_clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11 q", 32'(per_q), 32'h000B_0005);
    chk("R11 rdata", bus_rdata, 32'h0);
    chk("R11 wstb", 32'(per_wstb), 32'h0);

    for (int k = 0; k < 9; k++) begin
      bus_sel = 1'b1; bus_wr = VEC[k].wr; bus_rd = VEC[k].rd; bus_wdata = VEC[k].wd;
      per_in = VEC[k].pin; per_set = VEC[k].pset; per_clr = VEC[k].pclr;
      @(negedge clk);
      chk($sformatf("R%0d step %0d rdata", VEC[k].req, k), bus_rdata, VEC[k].erd);
      chk($sformatf("R%0d step %0d q", VEC[k].req, k), 32'(per_q), 32'(VEC[k].eq));
    end
    idle();
    @(negedge clk);
    chk("R10 idle rdata", bus_rdata, 32'h0);

    // R4: strobe pulses one cycle at RW and WO indices
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h0000_0A03;
    @(negedge clk);
    idle();
    chk("R4 wstb pulse", 32'(per_wstb), 32'h05);
    chk("R4 wo data", 32'(per_q), 32'h0008_EA03);
    @(negedge clk);
    chk("R4 wstb drop", 32'(per_wstb), 32'h0);

    // R12: strobes with select low do nothing
    bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    idle();
    chk("R12 q", 32'(per_q), 32'h0008_EA03);
    chk("R12 wstb", 32'(per_wstb), 32'h0);
    chk("R12 rdata", bus_rdata, 32'h0);

    // R1 / R3: upper bits zero and RO ignores writes
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h0000_00F3;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; per_in = 20'hFFFFF;
    @(negedge clk);
    idle();
    chk("R1 R3 rdata", bus_rdata, 32'h0008_E0F3);

    // R11: reset mid-run restores reset values
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 rerun q", 32'(per_q), 32'h000B_0005);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule